// File: doc/BRIEF.md
# Auxiliary Tap Output Selector

This block drives one diagnostic output pin from the digital section of a frequency synthesizer. It runs on the fast oscillator clock and holds an auxiliary counter that divides that clock by a programmable value A. The counter produces a pulse that is high for one input cycle in every A cycles. A toggle stage after the counter halves that rate again and gives a 50% duty square wave.

A registered multiplexer, controlled by a 3-bit select, places one of six sources on the pin:

- the reference divider tick,
- the feedback divider tick,
- the auxiliary pulse,
- the halved auxiliary wave,
- a fixed low level,
- a fixed high level.

Firmware sets the select and the divide value once. The pin is then used to observe internal divider activity, or to derive a lower-frequency clock from the oscillator.

Top module: `aux_tap_out`

## Requirements
- R1: With the select set to the auxiliary pulse, the output is periodic with a period of exactly A fast-clock cycles, for any A from 2 to 31.
- R2: The auxiliary pulse is high for exactly one fast-clock cycle in each period, so its duty is 1/A.
- R3: The halved source inverts once per auxiliary pulse. Its period is 2A cycles, and it is high for A cycles of each period.
- R4: Select code 000 drives a constant low and code 001 drives a constant high.
- R5: Select code 010 passes the reference tick and code 011 passes the feedback tick.
- R6: Select code 100 passes the auxiliary pulse and code 101 passes the halved wave.
- R7: Select codes 110 and 111 drive a constant low.
- R8: A divide input of 0 or 1 is treated as 2.
- R9: A divide value written partway through a period takes effect only when the current period ends. That period completes at its old length, so no shortened pulse appears.
- R10: While the synchronous active-high reset is held, the output is low, the counter is cleared and the halved stage is cleared to low.
- R11: The output is registered. It reflects the select and the source values sampled at the previous rising clock edge.

Ports of `aux_tap_out`:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | 5 | Auxiliary divide value A |
| sel_i | input | 3 | Output source select |
| ref_tick_i | input | 1 | Reference divider output tick |
| fb_tick_i | input | 1 | Feedback divider output tick |
| tap_o | output | 1 | Selected, registered output |

## Verification
On every cycle, assertions check the following:

- the one-cycle latency from each selected source to the pin, together with the fixed levels;
- that the active divide value stays in range and changes only at the terminal count;
- that auxiliary pulses never last two cycles in a row;
- that the halved stage changes exactly when a pulse is present.

Only the bench scenarios can show whole-period properties. These are the period and duty at the divide limits, the substitution of 2 for the out-of-range values 0 and 1, and a divide change in mid-period that leaves the running period at its old length.

// File: rtl/aux_tap_pkg.sv
package aux_tap_pkg;
  typedef enum logic [2:0] {
    TAP_LOW  = 3'b000,
    TAP_HIGH = 3'b001,
    TAP_REF  = 3'b010,
    TAP_FB   = 3'b011,
    TAP_AUX  = 3'b100,
    TAP_HALF = 3'b101
  } tap_sel_e;
endpackage

// File: rtl/aux_pulse_counter.sv
module aux_pulse_counter #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o
);
  localparam int MIN_DIV = 2;
  localparam logic [DIV_W-1:0] MIN_VAL = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt, lim, lim_next;
  logic terminal;

  // Out-of-range values fall back to the smallest legal divide (R8)
  assign lim_next = (div_i < MIN_VAL) ? MIN_VAL : div_i;
  assign terminal = (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim     <= lim_next;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= terminal;
      if (terminal) begin
        cnt <= '0;
        lim <= lim_next;   // new divide only at period end (R9)
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_div_range_R8: assert property (@(posedge clk) disable iff (rst)
    lim >= MIN_VAL);

  assert_single_cycle_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  assert_load_at_terminal_R9: assert property (@(posedge clk) disable iff (rst)
    !terminal |=> $stable(lim));
endmodule

// File: rtl/half_rate_toggle.sv
module half_rate_toggle (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic half_o
);
  always_ff @(posedge clk) begin
    if (rst) half_o <= 1'b0;
    else if (pulse_i) half_o <= ~half_o;
  end

  assert_toggle_on_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    pulse_i |=> (half_o != $past(half_o)));

  assert_hold_without_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    !pulse_i |=> $stable(half_o));
endmodule

// File: rtl/tap_select_reg.sv
module tap_select_reg
  import aux_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_i,
  input  logic       ref_i,
  input  logic       fb_i,
  input  logic       aux_i,
  input  logic       half_i,
  output logic       tap_o
);
  logic pick;

  always_comb begin
    case (tap_sel_e'(sel_i))
      TAP_HIGH: pick = 1'b1;
      TAP_REF:  pick = ref_i;
      TAP_FB:   pick = fb_i;
      TAP_AUX:  pick = aux_i;
      TAP_HALF: pick = half_i;
      default:  pick = 1'b0;   // TAP_LOW and unused codes (R7)
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tap_o <= 1'b0;
    else     tap_o <= pick;
  end

  assert_low_in_reset_R10: assert property (@(posedge clk)
    rst |=> !tap_o);

  assert_const_low_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_i == TAP_LOW) |=> !tap_o);

  assert_const_high_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_i == TAP_HIGH) |=> tap_o);

  assert_unused_low_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_i[2:1] == 2'b11) |=> !tap_o);

  assert_ref_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (sel_i == TAP_REF) |=> (tap_o == $past(ref_i)));

  assert_fb_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_i == TAP_FB) |=> (tap_o == $past(fb_i)));

  assert_aux_route_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_i == TAP_AUX) |=> (tap_o == $past(aux_i)));
endmodule

// File: rtl/aux_tap_out.sv
module aux_tap_out #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic [2:0]       sel_i,
  input  logic             ref_tick_i,
  input  logic             fb_tick_i,
  output logic             tap_o
);
  logic aux_pulse, half_wave;

  aux_pulse_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .div_i(div_i), .pulse_o(aux_pulse)
  );

  half_rate_toggle u_half (
    .clk(clk), .rst(rst), .pulse_i(aux_pulse), .half_o(half_wave)
  );

  tap_select_reg u_sel (
    .clk(clk), .rst(rst), .sel_i(sel_i), .ref_i(ref_tick_i), .fb_i(fb_tick_i),
    .aux_i(aux_pulse), .half_i(half_wave), .tap_o(tap_o)
  );
endmodule

// File: tb/aux_tap_out_test.sv
module aux_tap_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {sel[23:21], div[20:16], kind[15:14] (0 low,1 high,2 periodic), period[13:7], high[6:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {3'd0, 5'd4,  2'd0, 7'd0,  7'd0},
    {3'd1, 5'd4,  2'd1, 7'd0,  7'd0},
    {3'd2, 5'd4,  2'd2, 7'd7,  7'd1},
    {3'd3, 5'd4,  2'd2, 7'd5,  7'd1},
    {3'd4, 5'd2,  2'd2, 7'd2,  7'd1},
    {3'd4, 5'd31, 2'd2, 7'd31, 7'd1},
    {3'd4, 5'd9,  2'd2, 7'd9,  7'd1},
    {3'd5, 5'd3,  2'd2, 7'd6,  7'd3},
    {3'd5, 5'd31, 2'd2, 7'd62, 7'd31},
    {3'd4, 5'd0,  2'd2, 7'd2,  7'd1},
    {3'd4, 5'd1,  2'd2, 7'd2,  7'd1},
    {3'd5, 5'd1,  2'd2, 7'd4,  7'd2},
    {3'd6, 5'd4,  2'd0, 7'd0,  7'd0},
    {3'd7, 5'd4,  2'd0, 7'd0,  7'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] div_i = 5'd4;
  logic [2:0] sel_i = 3'd0;
  logic ref_tick_i = 1'b0, fb_tick_i = 1'b0;
  logic tap_o;
  int total = 0, bad = 0;

  aux_tap_out uut (.clk(clk), .rst(rst), .div_i(div_i), .sel_i(sel_i),
    .ref_tick_i(ref_tick_i), .fb_tick_i(fb_tick_i), .tap_o(tap_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference tick every 7 cycles, feedback tick every 5 cycles
  initial begin
    int rc = 0, fc = 0;
    forever begin
      @(negedge clk);
      rc = (rc == 6) ? 0 : rc + 1;
      fc = (fc == 4) ? 0 : fc + 1;
      ref_tick_i = (rc == 0);
      fb_tick_i  = (fc == 0);
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count negedges until tap rises; returns 255 on timeout
  task automatic wait_rise(output int n);
    logic pv = tap_o;
    n = 0;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk);
      n++;
      if (!pv && tap_o) return;
      pv = tap_o;
    end
    n = 255;
  endtask

  task automatic measure(output int per, output int hi);
    int d;
    logic pv;
    wait_rise(d);
    per = 0; hi = 0;
    for (int i = 0; i < 255; i++) begin
      hi += int'(tap_o);
      per++;
      pv = tap_o;
      @(negedge clk);
      if (!pv && tap_o) return;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic string req_of(logic [2:0] s, logic [4:0] d);
    if ((s == 3'd4 || s == 3'd5) && d < 5'd2) return "R8";
    case (s)
      3'd0, 3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4:       return (d == 5'd31 || d == 5'd2) ? "R1" : "R2";
      3'd5:       return "R3";
      default:    return "R7";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, n;
    // R10: output low while reset held, even with a high source selected
    sel_i = 3'd1;
    repeat (4) @(negedge clk);
    check("R10", int'(tap_o), 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] s;
      logic [4:0] d;
      logic [1:0] k;
      s = VEC[v][23:21]; d = VEC[v][20:16]; k = VEC[v][15:14];
      sel_i = s; div_i = d;
      do_reset();
      repeat (70) @(negedge clk);
      if (k == 2'd2) begin
        measure(per, hi);
        check(req_of(s, d), per, int'(VEC[v][13:7]));
        check(req_of(s, d), hi, int'(VEC[v][6:0]));
      end else begin
        int ok = 1;
        for (int i = 0; i < 64; i++) begin
          @(negedge clk);
          if (tap_o != k[0]) ok = 0;
        end
        check(req_of(s, d), ok, 1);
      end
    end

    // R11: select change appears after exactly one rising edge
    sel_i = 3'd0; do_reset();
    repeat (3) @(negedge clk);
    sel_i = 3'd1;
    #1 check("R11", int'(tap_o), 0);
    @(negedge clk);
    check("R11", int'(tap_o), 1);

    // R10: halved stage starts low after reset
    sel_i = 3'd5; div_i = 5'd4;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", int'(tap_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", int'(tap_o), 0);

    // R9: divide change in mid-period keeps the running period length
    sel_i = 3'd4; div_i = 5'd31; do_reset();
    wait_rise(n);
    repeat (5) @(negedge clk);
    div_i = 5'd3;
    wait_rise(n);
    check("R9", n + 5, 31);
    measure(per, hi);
    check("R9", per, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule